// File: doc/BRIEF.md
# Shared Bus Ownership Requester

This block is the requesting side of one master on an external bus that several masters share. A local request from a processor or DMA engine raises a bus request. An external arbiter answers with a grant. The block then waits for the current owner to leave the bus. The busy line is active low and wired-AND: it is the AND of every master's active-low acknowledge line.

Once the bus is free, the block pulls its own open-drain acknowledge low and becomes the owner. Its ownership flag can enable the external address, data and control buffers. Ownership is parked for as long as the grant stays up. Ownership is also held through a locked read-modify-write and through a transfer in progress, even when the grant is withdrawn.

When the block lets go, it drives the acknowledge line high for half a clock. It then floats the line, so a weak pull-up can hold it high.

Top module: `busown_ctrl`

## Requirements
- R1: While `rst_n` is low, `ack_oe_o` and `owner_o` are 0 whatever `grant_i` and `busy_n_i` do.
- R2: `breq_o` is 1 exactly when (`req_i` or `lock_i`) is 1 and the block is not the owner (`owner_o` = 0).
- R3: A rising edge that sees `grant_i` = 1 while the block is idle only makes it pending. While pending, an edge that sees `busy_n_i` = 0 leaves `ack_drv_o` = 1 and `owner_o` = 0, so ownership comes two edges after the grant at the earliest.
- R4: A pending block whose rising edge sees `grant_i` = 1 and `busy_n_i` = 1 becomes the owner at that edge: `owner_o` = 1, `ack_oe_o` = 1, `ack_drv_o` = 0.
- R5: If `grant_i` is seen at 0 while pending, the block returns to idle without ever driving the acknowledge low.
- R6: An owner stays owner (parking) on every edge where `grant_i` = 1, whatever `req_i` is.
- R7: An owner stays owner on every edge where `lock_i` = 1 or `xfer_i` = 1, even with `grant_i` = 0.
- R8: On the first rising edge where an owner sees `grant_i` = 0, `lock_i` = 0 and `xfer_i` = 0, `owner_o` falls and the acknowledge is driven high (`ack_drv_o` = 1, `ack_oe_o` = 1). `ack_oe_o` falls at the next falling clock edge. The block is idle after the following rising edge. This assumes the default half-cycle release mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_i | input | 1 | Local need for the bus (processor or DMA) |
| lock_i | input | 1 | Indivisible read-modify-write in progress |
| xfer_i | input | 1 | Bus transfer currently in progress |
| grant_i | input | 1 | Grant from the external arbiter, active high |
| busy_n_i | input | 1 | Shared bus-busy line, active low (0 = bus owned) |
| breq_o | output | 1 | Bus request to the arbiter |
| ack_drv_o | output | 1 | Value driven on the open-drain acknowledge (0 = asserted) |
| ack_oe_o | output | 1 | Drive enable of the acknowledge pin (0 = floated) |
| owner_o | output | 1 | Block is the current bus master; enables external buffers |

## Verification
The hardest case to reach is a pending master that holds a grant while another master still owns the bus. The bench builds it by raising the grant with the busy line held low for several edges, and only then releases busy. A grant that vanishes while pending is reached the same way, by dropping it before busy clears. The half-cycle release is checked just after the falling edge that follows the release edge.

// File: rtl/busown_pkg.sv
package busown_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_OWN  = 2'd2,
      ST_REL  = 2'd3
   } own_state_e;

   localparam int unsigned REL_FULL = 0;
   localparam int unsigned REL_HALF = 1;
endpackage

// File: rtl/busown_fsm.sv
module busown_fsm
   import busown_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       grant_i,
   input  logic       busy_n_i,
   input  logic       lock_i,
   input  logic       xfer_i,
   output own_state_e state_o
);
   own_state_e state_q, state_d;
   logic       hold_w;

   assign hold_w = grant_i | lock_i | xfer_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (grant_i) state_d = ST_PEND;
         ST_PEND: begin
            if (!grant_i)      state_d = ST_IDLE;
            else if (busy_n_i) state_d = ST_OWN;
         end
         ST_OWN:  if (!hold_w) state_d = ST_REL;
         ST_REL:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/busown_odrv.sv
module busown_odrv
   import busown_pkg::*;
#(
   parameter int unsigned RELEASE_MODE = REL_HALF
)(
   input  logic       clk,
   input  logic       rst_n,
   input  own_state_e state_i,
   output logic       ack_drv_o,
   output logic       ack_oe_o
);
   logic own_w, rel_w;

   assign own_w     = (state_i == ST_OWN);
   assign rel_w     = (state_i == ST_REL);
   assign ack_drv_o = !own_w;

   generate
      if (RELEASE_MODE == REL_HALF) begin : g_half
         logic cut_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) cut_q <= 1'b0;
            else        cut_q <= rel_w;
         end
         assign ack_oe_o = own_w | (rel_w & !cut_q);
      end else begin : g_full
         assign ack_oe_o = own_w | rel_w;
      end
   endgenerate
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
   import busown_pkg::*;
#(
   parameter int unsigned RELEASE_MODE = REL_HALF
)(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic lock_i,
   input  logic xfer_i,
   input  logic grant_i,
   input  logic busy_n_i,
   output logic breq_o,
   output logic ack_drv_o,
   output logic ack_oe_o,
   output logic owner_o
);
   generate
      if (RELEASE_MODE != REL_HALF && RELEASE_MODE != REL_FULL) begin : g_bad_mode
         $error("busown_ctrl: RELEASE_MODE must be 0 or 1");
      end
   endgenerate

   own_state_e state_w;

   busown_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant_i  (grant_i),
      .busy_n_i (busy_n_i),
      .lock_i   (lock_i),
      .xfer_i   (xfer_i),
      .state_o  (state_w)
   );

   busown_odrv #(.RELEASE_MODE(RELEASE_MODE)) u_odrv (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_i   (state_w),
      .ack_drv_o (ack_drv_o),
      .ack_oe_o  (ack_oe_o)
   );

   assign owner_o = (state_w == ST_OWN);
   assign breq_o  = (req_i | lock_i) & !owner_o;
endmodule

// File: rtl/busown_ctrl_chk.sv
module busown_ctrl_chk
   import busown_pkg::*;
#(
   parameter int unsigned RELEASE_MODE = REL_HALF
)(
   input logic       clk,
   input logic       rst_n,
   input logic       grant_i,
   input logic       busy_n_i,
   input logic       lock_i,
   input logic       xfer_i,
   input own_state_e state_i,
   input logic       ack_drv_o,
   input logic       ack_oe_o,
   input logic       owner_o
);
   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_float_R1: assert (!ack_oe_o && !owner_o);
      end
   end

   assert_wait_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_PEND && !busy_n_i) |=> ack_drv_o);

   assert_take_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owner_o) |-> ($past(busy_n_i) && $past(grant_i)));

   assert_owner_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      owner_o |-> (ack_oe_o && !ack_drv_o));

   assert_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_o && grant_i) |=> owner_o);

   assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_o && (lock_i || xfer_i)) |=> owner_o);

   generate
      if (RELEASE_MODE == REL_HALF) begin : g_half_chk
         assert_half_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(owner_o) |-> (ack_drv_o && !ack_oe_o));
      end
   endgenerate
endmodule

bind busown_ctrl busown_ctrl_chk #(.RELEASE_MODE(RELEASE_MODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant_i   (grant_i),
   .busy_n_i  (busy_n_i),
   .lock_i    (lock_i),
   .xfer_i    (xfer_i),
   .state_i   (state_w),
   .ack_drv_o (ack_drv_o),
   .ack_oe_o  (ack_oe_o),
   .owner_o   (owner_o)
);

// File: tb/busown_ctrl_tb.sv
`timescale 1ns/100ps
module busown_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0, lock_i = 1'b0, xfer_i = 1'b0;
   logic grant_i = 1'b0, busy_n_i = 1'b1;
   logic breq_o, ack_drv_o, ack_oe_o, owner_o;
   int   total = 0;
   int   bad = 0;
   bit   ended = 1'b0;

   always #2 clk = ~clk;

   busown_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
      .xfer_i(xfer_i), .grant_i(grant_i), .busy_n_i(busy_n_i),
      .breq_o(breq_o), .ack_drv_o(ack_drv_o), .ack_oe_o(ack_oe_o),
      .owner_o(owner_o)
   );

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; grant_i = 1'b1; busy_n_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R1 oe in reset", ack_oe_o, 1'b0);
         chk("R1 owner in reset", owner_o, 1'b0);
      end
      grant_i = 1'b0; rst_n = 1'b1;
      step();
      chk("R1 owner after reset", owner_o, 1'b0);
   endtask

   task automatic t_takeover();
      req_i = 1'b1; grant_i = 1'b1; busy_n_i = 1'b0;
      step();
      chk("R3 no owner at grant edge", owner_o, 1'b0);
      chk("R2 request while not owner", breq_o, 1'b1);
      step();
      chk("R3 drv high while busy", ack_drv_o, 1'b1);
      chk("R3 owner while busy", owner_o, 1'b0);
      chk("R3 oe while busy", ack_oe_o, 1'b0);
      busy_n_i = 1'b1;
      step();
      chk("R4 owner", owner_o, 1'b1);
      chk("R4 drv low", ack_drv_o, 1'b0);
      chk("R4 oe", ack_oe_o, 1'b1);
      chk("R2 request dropped as owner", breq_o, 1'b0);
      busy_n_i = 1'b0;
   endtask

   task automatic t_park();
      req_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R6 parked owner", owner_o, 1'b1);
      end
      chk("R2 no request idle", breq_o, 1'b0);
   endtask

   task automatic t_lock_release();
      grant_i = 1'b0; lock_i = 1'b1;
      step();
      chk("R7 lock holds", owner_o, 1'b1);
      lock_i = 1'b0; xfer_i = 1'b1;
      step();
      chk("R7 transfer holds", owner_o, 1'b1);
      xfer_i = 1'b0; req_i = 1'b1;
      step();
      chk("R8 owner fell", owner_o, 1'b0);
      chk("R8 drv high", ack_drv_o, 1'b1);
      chk("R8 oe first half", ack_oe_o, 1'b1);
      chk("R2 request after release", breq_o, 1'b1);
      @(negedge clk); #1;
      chk("R8 oe released", ack_oe_o, 1'b0);
      busy_n_i = 1'b1; req_i = 1'b0;
      step();
      chk("R8 idle oe", ack_oe_o, 1'b0);
      chk("R8 idle owner", owner_o, 1'b0);
   endtask

   task automatic t_abort();
      grant_i = 1'b1; busy_n_i = 1'b0;
      step();
      grant_i = 1'b0;
      step();
      chk("R5 no owner after abort", owner_o, 1'b0);
      chk("R5 drv high after abort", ack_drv_o, 1'b1);
      busy_n_i = 1'b1;
      step();
      chk("R5 stays idle", owner_o, 1'b0);
      chk("R5 oe off", ack_oe_o, 1'b0);
      grant_i = 1'b1;
      step();
      chk("R3 pending first", owner_o, 1'b0);
      step();
      chk("R4 owner after pending", owner_o, 1'b1);
      grant_i = 1'b0;
      step();
      chk("R8 release no hold", owner_o, 1'b0);
      step();
   endtask

   initial begin
      t_reset();
      t_takeover();
      t_park();
      t_lock_release();
      t_abort();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #80000;
      if (!ended) begin
         ended = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule